// File: doc/BRIEF.md
# Register Rename Status Table

This block is a register file in which every architectural register carries a pending flag and a producer tag. The tag names the reservation station that will write the register. When an instruction issues, its two source registers are looked up. Each lookup returns one of two things: the committed value, marked ready, or the tag of the station that will produce that value, marked not ready. In the same cycle the issuing instruction claims its destination register by writing its own station tag into that register's producer field.

Finished operations broadcast a tag and a data word on a result bus. Every register whose pending tag equals the broadcast tag takes the data and becomes ready again. A register that has since been claimed by a younger instruction names a different tag, so a late result from an older writer cannot overwrite it. This removes output-dependence hazards without stalling issue.

A result that arrives in the same cycle as a lookup is passed straight to the read port. If a claim and a matching broadcast land on the same register in the same cycle, the new claim is kept.

Top module: `rename_status_table`

## Requirements
- R1: After reset every register is not pending and holds zero, so any lookup returns ready with data 0.
- R2: A lookup of a register that is not pending returns ready = 1 and the register's stored value.
- R3: A lookup of a pending register returns ready = 0 and the register's producer tag on the tag output, unless R7 applies.
- R4: A claim (claim_en = 1) makes the claimed register pending with claim_tag, visible to lookups from the next cycle.
- R5: A broadcast (bc_en = 1) writes bc_data into every pending register whose tag equals bc_tag and clears their pending flags, visible from the next cycle.
- R6: A register whose pending tag differs from the broadcast tag keeps its value and tag, so an older writer cannot overwrite a register that a younger writer has claimed since.
- R7: A lookup of a pending register whose tag matches the broadcast of the same cycle returns ready = 1 with bc_data.
- R8: When a register is claimed and matched by a broadcast in the same cycle, it ends that cycle pending with the new claim tag.
- R9: Lookups in a claim cycle see the state from before that claim, including a source that is the same register as the destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | IW | First source register index |
| rd_a_ready | output | 1 | First source value available |
| rd_a_data | output | DW | First source value (meaningful when ready) |
| rd_a_tag | output | TW | First source producer tag (meaningful when not ready) |
| rd_b_idx | input | IW | Second source register index |
| rd_b_ready | output | 1 | Second source value available |
| rd_b_data | output | DW | Second source value (meaningful when ready) |
| rd_b_tag | output | TW | Second source producer tag (meaningful when not ready) |
| claim_en | input | 1 | Destination claim strobe |
| claim_idx | input | IW | Destination register index |
| claim_tag | input | TW | Station tag of the issuing instruction |
| bc_en | input | 1 | Result broadcast strobe |
| bc_tag | input | TW | Tag of the finishing station |
| bc_data | input | DW | Result value |

## Verification
The bench builds the table with 4 registers, 8-bit data and 2-bit tags. At that size tags collide often and several registers frequently share one pending tag. A long pseudo-random run therefore hits same-cycle bypass, claim-versus-broadcast collisions and stale-writer drops many times. The read indices step through every pair of registers, and each lookup is compared with an arithmetic model of the table.

// File: rtl/rename_status_table.sv
module rename_status_table #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int TW   = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_a_idx,
  output logic          rd_a_ready,
  output logic [DW-1:0] rd_a_data,
  output logic [TW-1:0] rd_a_tag,
  input  logic [IW-1:0] rd_b_idx,
  output logic          rd_b_ready,
  output logic [DW-1:0] rd_b_data,
  output logic [TW-1:0] rd_b_tag,
  input  logic          claim_en,
  input  logic [IW-1:0] claim_idx,
  input  logic [TW-1:0] claim_tag,
  input  logic          bc_en,
  input  logic [TW-1:0] bc_tag,
  input  logic [DW-1:0] bc_data
);

  logic [DW-1:0]   val_q [NREG];
  logic [TW-1:0]   tag_q [NREG];
  logic [NREG-1:0] busy_q;
  logic [NREG-1:0] match;
  logic [NREG-1:0] claim_hit;

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      assign match[g]     = bc_en && busy_q[g] && (tag_q[g] == bc_tag);
      assign claim_hit[g] = claim_en && (claim_idx == IW'(g));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          val_q[g]  <= '0;
          tag_q[g]  <= '0;
          busy_q[g] <= 1'b0;
        end else begin
          if (match[g]) val_q[g] <= bc_data;
          if (claim_hit[g]) begin
            busy_q[g] <= 1'b1;
            tag_q[g]  <= claim_tag;
          end else if (match[g]) begin
            busy_q[g] <= 1'b0;
          end
        end
      end

      assert_match_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (match[g] && !claim_hit[g]) |=> (!busy_q[g] && val_q[g] == $past(bc_data)));

      assert_claim_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        claim_hit[g] |=> (busy_q[g] && tag_q[g] == $past(claim_tag)));

      assert_value_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !match[g] |=> $stable(val_q[g]));
    end
  endgenerate

  assign rd_a_ready = !busy_q[rd_a_idx] || match[rd_a_idx];
  assign rd_a_data  = match[rd_a_idx] ? bc_data : val_q[rd_a_idx];
  assign rd_a_tag   = tag_q[rd_a_idx];

  assign rd_b_ready = !busy_q[rd_b_idx] || match[rd_b_idx];
  assign rd_b_data  = match[rd_b_idx] ? bc_data : val_q[rd_b_idx];
  assign rd_b_tag   = tag_q[rd_b_idx];

  assert_bypass_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_en && busy_q[rd_a_idx] && tag_q[rd_a_idx] == bc_tag) |-> (rd_a_ready && rd_a_data == bc_data));

  assert_pending_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_b_ready |-> (busy_q[rd_b_idx] && !(bc_en && rd_b_tag == bc_tag)));

endmodule

// File: tb/sim_rename_status_table.sv
module sim_rename_status_table;
  localparam int NREG = 4, DW = 8, TW = 2, IW = 2;

  logic clk = 0, rst_n = 0;
  logic [IW-1:0] rd_a_idx = 0, rd_b_idx = 0, claim_idx = 0;
  logic rd_a_ready, rd_b_ready, claim_en = 0, bc_en = 0;
  logic [DW-1:0] rd_a_data, rd_b_data, bc_data = 0;
  logic [TW-1:0] rd_a_tag, rd_b_tag, claim_tag = 0, bc_tag = 0;

  rename_status_table #(.NREG(NREG), .DW(DW), .TW(TW)) u0 (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  logic [DW-1:0] m_val [NREG];
  logic [TW-1:0] m_tag [NREG];
  logic          m_busy [NREG];
  logic [31:0]   rng = 32'h1234_5678;

  task automatic check(input string req, input int idx, input logic rdy,
                       input logic [DW-1:0] d, input logic [TW-1:0] t);
    logic hit, erdy;
    logic [DW-1:0] ed;
    string r;
    hit  = bc_en && m_busy[idx] && (m_tag[idx] == bc_tag);
    erdy = !m_busy[idx] || hit;
    ed   = hit ? bc_data : m_val[idx];
    r    = req;
    if (r == "") r = !m_busy[idx] ? "R2" : (hit ? "R7" : "R3");
    total++;
    if (rdy !== erdy) begin
      bad++; $display("FAIL %s reg%0d ready=%b expected %b", r, idx, rdy, erdy);
    end else if (erdy && d !== ed) begin
      bad++; $display("FAIL %s reg%0d data=%0h expected %0h", r, idx, d, ed);
    end else if (!erdy && t !== m_tag[idx]) begin
      bad++; $display("FAIL %s reg%0d tag=%0d expected %0d", r, idx, t, m_tag[idx]);
    end
  endtask

  task automatic cyc(input string req, input logic ce, input int ci, input int ct,
                     input logic be, input int bt, input int bd, input int ai, input int bi);
    @(negedge clk);
    claim_en = ce; claim_idx = IW'(ci); claim_tag = TW'(ct);
    bc_en = be; bc_tag = TW'(bt); bc_data = DW'(bd);
    rd_a_idx = IW'(ai); rd_b_idx = IW'(bi);
    #2;
    check(req, ai, rd_a_ready, rd_a_data, rd_a_tag);
    check(req, bi, rd_b_ready, rd_b_data, rd_b_tag);
    @(posedge clk);
    for (int i = 0; i < NREG; i++) begin
      logic m;
      m = be && m_busy[i] && (m_tag[i] == TW'(bt));
      if (m) m_val[i] = DW'(bd);
      if (ce && ci == i) begin m_busy[i] = 1; m_tag[i] = TW'(ct); end
      else if (m) m_busy[i] = 0;
    end
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin m_val[i] = 0; m_tag[i] = 0; m_busy[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: reset state on every register
    cyc("R1", 0, 0, 0, 0, 0, 0, 0, 1);
    cyc("R1", 0, 0, 0, 0, 0, 0, 2, 3);
    // R4: claim then lookup; R9: same-cycle lookup sees pre-claim state
    cyc("R9", 1, 1, 2, 0, 0, 0, 1, 1);
    cyc("R4", 0, 0, 0, 0, 0, 0, 1, 0);
    // R5: two registers share tag 3, one broadcast fills both
    cyc("", 1, 0, 3, 0, 0, 0, 2, 3);
    cyc("", 1, 3, 3, 0, 0, 0, 2, 2);
    cyc("R7", 0, 0, 0, 1, 3, 'h5A, 0, 3);
    cyc("R5", 0, 0, 0, 0, 0, 0, 0, 3);
    // R6: older writer tag 1, younger writer tag 2, stale result for tag 1
    cyc("", 1, 2, 1, 0, 0, 0, 0, 0);
    cyc("", 1, 2, 2, 0, 0, 0, 0, 0);
    cyc("R6", 0, 0, 0, 1, 1, 'hEE, 2, 0);
    cyc("R6", 0, 0, 0, 0, 0, 0, 2, 3);
    // R8: claim and matching broadcast collide on register 2
    cyc("", 1, 2, 0, 1, 2, 'h33, 2, 1);
    cyc("R8", 0, 0, 0, 0, 0, 0, 2, 2);
    cyc("", 0, 0, 0, 1, 0, 'h77, 2, 2);
    cyc("R5", 0, 0, 0, 0, 0, 0, 2, 1);
    // pseudo-random sweep, read pairs stepped over all combinations
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      r = rng;
      cyc("", r[0] & r[1], int'(r[3:2]), int'(r[5:4]), r[6] | r[7], int'(r[9:8]),
          int'(r[17:10]), n % 4, (n / 4) % 4);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule